// File: doc/BRIEF.md
# Locked index/data port bridge to a 32-bit bus

This block is a host-facing configuration slave reached through two byte-wide I/O ports. One port holds an index and the other gives access to the register that the index selects. Both ports stay sealed until a fixed two-byte key has been written to the index port. After that the host chooses a logical device by number. When that number matches the bridge device, the host can reach a small bank of staging registers.

The staging bank holds a 32-bit target address, a 32-bit data word and a transfer size code. A trigger register starts a single 32-bit transaction on an internal request/acknowledge bus. A write of a key value to the trigger starts a bus write of the staged word. A read of the trigger starts a bus read, and the returned word lands in the data bytes when the acknowledge arrives. Firmware uses this path to reach memory-mapped resources behind the bridge one word at a time.

Top module: `sio_bridge`

## Requirements
- R1: After reset the ports are locked, the device number, the enable bit, the index and all staging bytes are 0x00, and `busReq` and `busy` are low.
- R2: Writing 0xA5 to the index port (0x2E) twice in a row unlocks the ports. Any other access to either port in between restarts the sequence. While locked, reads of either port return 0xFF and writes to the data port (0x2F) have no effect.
- R3: When unlocked, a write to 0x2E selects an index, a read of 0x2E returns that index, and 0x2F reads and writes the selected register. Index 0x07 holds the logical device number.
- R4: Indices 0x30, 0xF0–0xF8 and 0xFE respond only while the device number is 0x0D. Otherwise they read 0xFF and ignore writes.
- R5: Indices 0xF0–0xF3 hold the address bytes and 0xF4–0xF7 hold the data bytes, each with the most significant byte at the lower index. A launch presents these words on `busAddr` and `busWData`.
- R6: Bit 0 of index 0x30 is the enable and reads back as {7'b0, enable}. No launch happens while the enable is 0.
- R7: Writing 0xCF to index 0xFE, with the bridge enabled, idle and size code 2, raises `busReq` with `busWrite` high on the next cycle. Any other value written there has no effect.
- R8: Reading index 0xFE under the same conditions raises `busReq` with `busWrite` low. On the acknowledge, `busRData` is loaded into the data bytes.
- R9: `busReq` stays high, with address, data and direction stable, until the first cycle in which `busAck` is high. `busy` follows it. Index 0xFE reads 0x01 while busy. Triggers during busy are ignored. The data bytes change only on a read acknowledge.
- R10: Index 0xF8 holds a readable size code. A trigger with a code other than 2 is ignored.
- R11: Unimplemented indices read 0xFF, and writes to them change nothing.
- R12: Writing 0xAA to the index port, while unlocked, locks the ports again. The index value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Host byte write strobe |
| ioRdEn | input | 1 | Host byte read strobe |
| ioAddr | input | 16 | Host port address |
| ioWrData | input | 8 | Host write byte |
| ioRdData | output | 8 | Host read byte (combinational) |
| busReq | output | 1 | Internal bus request, held until acknowledged |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 32 | Internal bus address |
| busWData | output | 32 | Internal bus write data |
| busAck | input | 1 | Internal bus acknowledge |
| busRData | input | 32 | Internal bus read data, valid with the acknowledge |
| busy | output | 1 | A transaction is outstanding |

## Verification
The bench attacks the unlock key with a broken sequence, where a foreign index write or a data-port read sits between the two key bytes. A design that only counted key bytes would unlock early. It stages bytes while the device number is wrong, then reads them back after selecting the right device. A design without the device gate would show the stray write. Triggers are issued while the bridge is disabled, while it is busy, with a wrong key value and with a wrong size code. In each case a faulty design would raise a spurious request or overwrite the held address. Read data is sampled before and after the acknowledge, to catch a design that loads the data bytes too early or loads them in the wrong byte order.

// File: rtl/sio_bridge_pkg.sv
package sio_bridge_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  localparam logic [7:0] KEY_UNLOCK = 8'hA5;
  localparam logic [7:0] KEY_LOCK   = 8'hAA;
  localparam logic [7:0] KEY_GO     = 8'hCF;
  localparam logic [7:0] SIZE_WORD  = 8'h02;

  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ENABLE = 8'h30;
  localparam logic [7:0] IDX_ADDR0  = 8'hF0;
  localparam logic [7:0] IDX_DATA0  = 8'hF4;
  localparam logic [7:0] IDX_SIZE   = 8'hF8;
  localparam logic [7:0] IDX_TRIG   = 8'hFE;

  typedef struct packed {
    logic [WORD_BYTES-1:0] addrWe;
    logic [WORD_BYTES-1:0] dataWe;
    logic                  sizeWe;
    logic                  launch;
    logic                  launchWr;
    logic                  capture;
  } strobes_t;
endpackage

// File: rtl/sio_bridge_ctrl.sv
module sio_bridge_ctrl
  import sio_bridge_pkg::*;
#(
  parameter int             IO_AW      = 16,
  parameter logic [IO_AW-1:0] INDEX_PORT = 16'h002E,
  parameter logic [IO_AW-1:0] DATA_PORT  = 16'h002F,
  parameter logic [7:0]     DEV_NUM    = 8'h0D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWrEn,
  input  logic             ioRdEn,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [7:0]       ioWrData,
  output logic [7:0]       ioRdData,
  input  logic [7:0]       dpRdByte,
  input  logic [7:0]       sizeCode,
  input  logic             busAck,
  output logic             busyQ,
  output logic             lockedQ,
  output logic [7:0]       indexQ,
  output strobes_t         strb
);
  logic       halfKeyQ;
  logic [7:0] ldnQ;
  logic       enQ;
  logic       idxWr, datWr, datRd, anyAcc, devSel, canLaunch, ackSeen, stagedIdx;

  assign idxWr     = ioWrEn && (ioAddr == INDEX_PORT);
  assign datWr     = ioWrEn && (ioAddr == DATA_PORT);
  assign datRd     = ioRdEn && (ioAddr == DATA_PORT);
  assign anyAcc    = (ioWrEn || ioRdEn) && ((ioAddr == INDEX_PORT) || (ioAddr == DATA_PORT));
  assign devSel    = (ldnQ == DEV_NUM);
  assign ackSeen   = busyQ && busAck;
  assign canLaunch = !lockedQ && devSel && enQ && !busyQ && (sizeCode == SIZE_WORD);
  assign stagedIdx = (indexQ >= IDX_ADDR0) && (indexQ <= IDX_SIZE);

  // Strobes towards the datapath
  always_comb begin
    strb = '0;
    if (datWr && !lockedQ && devSel) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        strb.addrWe[k] = (indexQ == IDX_ADDR0 + 8'(k));
        strb.dataWe[k] = (indexQ == IDX_DATA0 + 8'(k));
      end
      strb.sizeWe = (indexQ == IDX_SIZE);
    end
    strb.launchWr = datWr && (indexQ == IDX_TRIG) && (ioWrData == KEY_GO) && canLaunch;
    strb.launch   = strb.launchWr || (datRd && (indexQ == IDX_TRIG) && canLaunch);
    strb.capture  = ackSeen;
  end

  // Lock, index, device number, enable, busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ  <= 1'b1;
      halfKeyQ <= 1'b0;
      indexQ   <= 8'h00;
      ldnQ     <= 8'h00;
      enQ      <= 1'b0;
      busyQ    <= 1'b0;
    end else begin
      if (lockedQ) begin
        if (idxWr && (ioWrData == KEY_UNLOCK)) begin
          if (halfKeyQ) begin
            lockedQ  <= 1'b0;
            halfKeyQ <= 1'b0;
          end else begin
            halfKeyQ <= 1'b1;
          end
        end else if (anyAcc) begin
          halfKeyQ <= 1'b0;
        end
      end else begin
        if (idxWr) begin
          if (ioWrData == KEY_LOCK) lockedQ <= 1'b1;
          else                      indexQ  <= ioWrData;
        end
        if (datWr && (indexQ == IDX_LDN)) ldnQ <= ioWrData;
        if (datWr && devSel && (indexQ == IDX_ENABLE)) enQ <= ioWrData[0];
      end
      if (strb.launch)  busyQ <= 1'b1;
      else if (ackSeen) busyQ <= 1'b0;
    end
  end

  // Host read mux
  always_comb begin
    ioRdData = 8'hFF;
    if (!lockedQ) begin
      if (ioAddr == INDEX_PORT) begin
        ioRdData = indexQ;
      end else if (ioAddr == DATA_PORT) begin
        if (indexQ == IDX_LDN) begin
          ioRdData = ldnQ;
        end else if (devSel) begin
          if (indexQ == IDX_ENABLE)    ioRdData = {7'b0, enQ};
          else if (stagedIdx)          ioRdData = dpRdByte;
          else if (indexQ == IDX_TRIG) ioRdData = {7'b0, busyQ};
        end
      end
    end
  end
endmodule

// File: rtl/sio_bridge_dp.sv
module sio_bridge_dp
  import sio_bridge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           ioWrData,
  input  strobes_t             strb,
  input  logic [7:0]           indexQ,
  input  logic [WORD_BITS-1:0] busRData,
  output logic [7:0]           dpRdByte,
  output logic [7:0]           sizeCode,
  output logic [WORD_BITS-1:0] busAddr,
  output logic [WORD_BITS-1:0] busWData,
  output logic                 busWrite
);
  logic [7:0]           addrB [WORD_BYTES];
  logic [7:0]           dataB [WORD_BYTES];
  logic [7:0]           sizeQ;
  logic [WORD_BITS-1:0] addrWord, dataWord;

  // Byte k sits at the lower index and carries the more significant bits
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    localparam int LO = 8 * (WORD_BYTES - 1 - k);
    always_ff @(posedge clk) begin
      if (!rstN)               addrB[k] <= 8'h00;
      else if (strb.addrWe[k]) addrB[k] <= ioWrData;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                         dataB[k] <= 8'h00;
      else if (strb.capture && !busWrite) dataB[k] <= busRData[LO +: 8];
      else if (strb.dataWe[k])           dataB[k] <= ioWrData;
    end
    assign addrWord[LO +: 8] = addrB[k];
    assign dataWord[LO +: 8] = dataB[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            sizeQ <= 8'h00;
    else if (strb.sizeWe) sizeQ <= ioWrData;
  end
  assign sizeCode = sizeQ;

  // Transaction registers, frozen at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr  <= '0;
      busWData <= '0;
      busWrite <= 1'b0;
    end else if (strb.launch) begin
      busAddr  <= addrWord;
      busWData <= dataWord;
      busWrite <= strb.launchWr;
    end
  end

  always_comb begin
    dpRdByte = 8'hFF;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (indexQ == IDX_ADDR0 + 8'(k)) dpRdByte = addrB[k];
      if (indexQ == IDX_DATA0 + 8'(k)) dpRdByte = dataB[k];
    end
    if (indexQ == IDX_SIZE) dpRdByte = sizeQ;
  end
endmodule

// File: rtl/sio_bridge.sv
module sio_bridge
  import sio_bridge_pkg::*;
#(
  parameter int             IO_AW      = 16,
  parameter logic [IO_AW-1:0] INDEX_PORT = 16'h002E,
  parameter logic [IO_AW-1:0] DATA_PORT  = 16'h002F,
  parameter logic [7:0]     DEV_NUM    = 8'h0D
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ioWrEn,
  input  logic                 ioRdEn,
  input  logic [IO_AW-1:0]     ioAddr,
  input  logic [7:0]           ioWrData,
  output logic [7:0]           ioRdData,
  output logic                 busReq,
  output logic                 busWrite,
  output logic [WORD_BITS-1:0] busAddr,
  output logic [WORD_BITS-1:0] busWData,
  input  logic                 busAck,
  input  logic [WORD_BITS-1:0] busRData,
  output logic                 busy
);
  strobes_t   strb;
  logic [7:0] dpRdByte, sizeCode, indexQ;
  logic       busyQ, lockedW;

  sio_bridge_ctrl #(
    .IO_AW(IO_AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .DEV_NUM(DEV_NUM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .dpRdByte(dpRdByte), .sizeCode(sizeCode),
    .busAck(busAck), .busyQ(busyQ), .lockedQ(lockedW), .indexQ(indexQ), .strb(strb)
  );

  sio_bridge_dp u_dp (
    .clk(clk), .rstN(rstN), .ioWrData(ioWrData), .strb(strb), .indexQ(indexQ),
    .busRData(busRData), .dpRdByte(dpRdByte), .sizeCode(sizeCode),
    .busAddr(busAddr), .busWData(busWData), .busWrite(busWrite)
  );

  assign busReq = busyQ;
  assign busy   = busyQ;
endmodule

// File: rtl/sio_bridge_chk.sv
module sio_bridge_chk #(
  parameter int             IO_AW     = 16,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h002F
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioWrEn,
  input logic             ioRdEn,
  input logic [IO_AW-1:0] ioAddr,
  input logic [7:0]       ioWrData,
  input logic [7:0]       ioRdData,
  input logic             busReq,
  input logic             busWrite,
  input logic [31:0]      busAddr,
  input logic [31:0]      busWData,
  input logic             busAck,
  input logic             lockedW
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq); // R9
  AST_TXN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr) && $stable(busWData) && $stable(busWrite)); // R9
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq); // R9
  AST_LAUNCH_FROM_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(ioWrEn || ioRdEn) && ($past(ioAddr) == DATA_PORT)); // R8
  AST_WRITE_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) && busWrite |-> $past(ioWrEn) && ($past(ioWrData) == 8'hCF)); // R7
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rstN)
    lockedW && ioRdEn && (ioAddr == DATA_PORT) |-> ioRdData == 8'hFF); // R2
endmodule

bind sio_bridge sio_bridge_chk #(.IO_AW(IO_AW), .DATA_PORT(DATA_PORT)) u_chk (.*);

// File: tb/sio_bridge_tb.sv
module sio_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PI = 16'h002E;
  localparam logic [15:0] PD = 16'h002F;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0, ioRdData;
  logic        busReq, busWrite, busy;
  logic [31:0] busAddr, busWData;
  logic        busAck = 1'b0;
  logic [31:0] busRData = '0;

  int checks = 0, errors = 0;
  logic [7:0] lastRd;

  // reference model state
  bit         mLocked, mHalf, mEn, mReq, mWr;
  bit         iw, dw, dr, anyA, dev, can, goW, goR, wasLocked;
  logic [7:0] mIdx, mLdn, mSize;
  logic [31:0] mAddr, mData, mBA, mBD;
  int         k;

  sio_bridge u_dut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busAck(busAck), .busRData(busRData), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on every clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mLocked = 1; mHalf = 0; mIdx = 0; mLdn = 0; mEn = 0; mSize = 0;
      mAddr = 0; mData = 0; mReq = 0; mWr = 0; mBA = 0; mBD = 0;
    end else begin
      iw   = ioWrEn && ioAddr == PI;
      dw   = ioWrEn && ioAddr == PD;
      dr   = ioRdEn && ioAddr == PD;
      anyA = (ioWrEn || ioRdEn) && (ioAddr == PI || ioAddr == PD);
      dev  = mLdn == 8'h0D;
      can  = !mLocked && dev && mEn && !mReq && mSize == 8'h02;
      goW  = dw && mIdx == 8'hFE && ioWrData == 8'hCF && can;
      goR  = dr && mIdx == 8'hFE && can;
      wasLocked = mLocked;
      if (goW || goR) begin mBA = mAddr; mBD = mData; mWr = goW; end
      if (!wasLocked && dw) begin
        if (mIdx == 8'h07) mLdn = ioWrData;
        if (dev) begin
          k = int'(mIdx) - 'hF0;
          if (mIdx == 8'h30) mEn = ioWrData[0];
          if (k >= 0 && k < 4) mAddr[8*(3-k) +: 8] = ioWrData;
          if (k >= 4 && k < 8) mData[8*(7-k) +: 8] = ioWrData;
          if (mIdx == 8'hF8) mSize = ioWrData;
        end
      end
      if (mReq && busAck) begin
        if (!mWr) mData = busRData;
        mReq = 0;
      end else if (goW || goR) mReq = 1;
      if (wasLocked) begin
        if (iw && ioWrData == 8'hA5) begin
          if (mHalf) begin mLocked = 0; mHalf = 0; end else mHalf = 1;
        end else if (anyA) mHalf = 0;
      end else if (iw) begin
        if (ioWrData == 8'hAA) mLocked = 1; else mIdx = ioWrData;
      end
    end
  end

  function automatic logic [7:0] mRead(input logic [15:0] p);
    int j;
    if (mLocked) return 8'hFF;
    if (p == PI) return mIdx;
    if (p != PD) return 8'hFF;
    if (mIdx == 8'h07) return mLdn;
    if (mLdn != 8'h0D) return 8'hFF;
    j = int'(mIdx) - 'hF0;
    if (mIdx == 8'h30) return {7'b0, mEn};
    if (j >= 0 && j < 4) return mAddr[8*(3-j) +: 8];
    if (j >= 4 && j < 8) return mData[8*(7-j) +: 8];
    if (mIdx == 8'hF8) return mSize;
    if (mIdx == 8'hFE) return {7'b0, mReq};
    return 8'hFF;
  endfunction

  // per-clock comparison of the bus side
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 busReq vs model", busReq, mReq);
      chk("R9 busy vs model", busy, mReq);
      if (mReq) begin
        chk("R5 busAddr vs model", busAddr, mBA);
        chk("R5 busWData vs model", busWData, mBD);
        chk("R7 busWrite vs model", busWrite, mWr);
      end
    end
  end

  // one host access; called just after a falling edge
  task automatic io(input bit wr, input logic [15:0] p, input logic [7:0] v, input string tag);
    ioWrEn = wr; ioRdEn = !wr; ioAddr = p; ioWrData = v;
    #1;
    if (!wr) begin
      lastRd = ioRdData;
      chk({tag, " read vs model"}, ioRdData, mRead(p));
    end
    @(negedge clk);
    ioWrEn = 0; ioRdEn = 0;
  endtask

  task automatic rd(input logic [15:0] p, input logic [7:0] exp, input string tag);
    io(0, p, 8'h00, tag);
    chk(tag, lastRd, exp);
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] v, input string tag);
    io(1, PI, idx, tag);
    io(1, PD, v, tag);
  endtask

  task automatic ack(input logic [31:0] d);
    busAck = 1; busRData = d;
    @(negedge clk);
    busAck = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 busReq after reset", busReq, 0);
    chk("R1 busy after reset", busy, 0);
    rd(PD, 8'hFF, "R1 locked after reset");
    // R2 broken key sequences
    io(1, PI, 8'hA5, "R2");
    io(1, PI, 8'h07, "R2");
    io(1, PI, 8'hA5, "R2");
    rd(PD, 8'hFF, "R2 still locked");
    io(1, PI, 8'hA5, "R2");
    io(1, PI, 8'hA5, "R2");
    rd(PI, 8'h00, "R2 unlocked index read");
    // R3 device number
    wreg(8'h07, 8'h0D, "R3");
    rd(PD, 8'h0D, "R3 ldn readback");
    rd(PI, 8'h07, "R3 index readback");
    // R4 device gate
    wreg(8'h07, 8'h05, "R4");
    wreg(8'hF0, 8'h77, "R4");
    rd(PD, 8'hFF, "R4 gated read");
    wreg(8'h07, 8'h0D, "R4");
    io(1, PI, 8'hF0, "R4");
    rd(PD, 8'h00, "R4 gated write ignored");
    // R5 staging
    wreg(8'hF0, 8'h12, "R5"); wreg(8'hF1, 8'h34, "R5");
    wreg(8'hF2, 8'h56, "R5"); wreg(8'hF3, 8'h78, "R5");
    wreg(8'hF4, 8'hCA, "R5"); wreg(8'hF5, 8'hFE, "R5");
    wreg(8'hF6, 8'hBA, "R5"); wreg(8'hF7, 8'hBE, "R5");
    wreg(8'hF8, 8'h02, "R10");
    io(1, PI, 8'hF3, "R5");
    rd(PD, 8'h78, "R5 low address byte");
    // R6 disabled launch
    wreg(8'hFE, 8'hCF, "R6");
    chk("R6 no launch when disabled", busReq, 0);
    io(1, PI, 8'h30, "R6");
    rd(PD, 8'h00, "R6 enable reads 0");
    io(1, PD, 8'h01, "R6");
    rd(PD, 8'h01, "R6 enable reads 1");
    // R7 wrong key, then write launch
    wreg(8'hFE, 8'h55, "R7");
    chk("R7 wrong key ignored", busReq, 0);
    io(1, PD, 8'hCF, "R7");
    chk("R7 busReq raised", busReq, 1);
    chk("R7 busWrite high", busWrite, 1);
    chk("R5 busAddr order", busAddr, 32'h12345678);
    chk("R5 busWData order", busWData, 32'hCAFEBABE);
    // R9 busy behaviour
    rd(PD, 8'h01, "R9 busy flag");
    wreg(8'hF0, 8'h99, "R9");
    wreg(8'hFE, 8'hCF, "R9");
    chk("R9 address held while busy", busAddr, 32'h12345678);
    repeat (2) @(negedge clk);
    chk("R9 request held", busReq, 1);
    ack(32'h0);
    chk("R9 request drops on ack", busReq, 0);
    io(1, PI, 8'hF4, "R9");
    rd(PD, 8'hCA, "R9 write ack leaves data");
    // R8 read launch
    io(1, PI, 8'hFE, "R8");
    io(0, PD, 8'h00, "R8");
    chk("R8 read busReq", busReq, 1);
    chk("R8 read direction", busWrite, 0);
    chk("R5 read address", busAddr, 32'h99345678);
    io(1, PI, 8'hF4, "R9");
    rd(PD, 8'hCA, "R9 data unchanged before ack");
    ack(32'hDEADBEEF);
    rd(PD, 8'hDE, "R8 read data high byte");
    io(1, PI, 8'hF7, "R8");
    rd(PD, 8'hEF, "R8 read data low byte");
    // R10 size code
    wreg(8'hF8, 8'h01, "R10");
    rd(PD, 8'h01, "R10 size readback");
    wreg(8'hFE, 8'hCF, "R10");
    chk("R10 write ignored with size 1", busReq, 0);
    rd(PD, 8'h00, "R10 read trigger ignored with size 1");
    chk("R10 no read launch", busReq, 0);
    wreg(8'hF8, 8'h02, "R10");
    // R11 unimplemented index
    io(1, PI, 8'h55, "R11");
    rd(PD, 8'hFF, "R11 unimplemented reads FF");
    io(1, PD, 8'h12, "R11");
    io(1, PI, 8'hF0, "R11");
    rd(PD, 8'h99, "R11 no side effect");
    // R12 relock
    io(1, PI, 8'hFE, "R12");
    io(1, PI, 8'hAA, "R12");
    rd(PD, 8'hFF, "R12 locked data read");
    io(1, PD, 8'hCF, "R12");
    chk("R12 trigger ignored while locked", busReq, 0);
    rd(PI, 8'hFF, "R12 locked index read");
    io(1, PI, 8'hA5, "R12");
    io(1, PI, 8'hA5, "R12");
    rd(PI, 8'hFE, "R12 index kept");
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule